// File: doc/BRIEF.md
# Drive Position and Media-Change Tracker

This block holds the per-drive mechanical state that sits behind a disk controller's command sequencer. For every attached drive it keeps the present cylinder number, the head last selected, whether media is loaded and a disk-change flag. The sequencer hands it decoded seek requests. A request is either an absolute target cylinder or a signed relative count, given as a direction plus a magnitude. The block then moves the stored cylinder, reports whether a step took place, and pulses a completion strobe that the sequencer can turn into its interrupt.

The disk-change flag is sticky. Reading it does not clear it. The flag stays set for as long as a drive is empty. Ejecting media sets it. Inserting media leaves it set. It falls only when a seek really moves the head to a different cylinder while media is loaded. A status read strobe captures the flag of the selected drive into an eight-bit status byte, at bit 7. Physical stepper timing and command byte parsing stay outside this block.

Top module: `fdt_drive_tracker`

## Requirements
- R1: After reset every drive reports cylinder 0, head 0, no media and the disk-change flag set. `seek_done`, `step_evt` and `dir_data` are 0.
- R2: An absolute seek (`seek_mode` = 0, or 3) loads the target into the drive's cylinder, clamped to MAX_CYL. It also records `seek_head` for that drive.
- R3: An inward relative seek (`seek_mode` = 1) adds `seek_value` to the present cylinder, saturating at MAX_CYL.
- R4: An outward relative seek (`seek_mode` = 2) subtracts `seek_value` from the present cylinder, saturating at 0.
- R5: `seek_done` is high for exactly the one cycle after each cycle in which `seek_req` is high, whether or not the head moved. It is low otherwise.
- R6: `step_evt` pulses in the same cycle as `seek_done`, and only when the new cylinder differs from the old one.
- R7: While media is present, a seek that changes the cylinder clears the disk-change flag. A seek to the cylinder already occupied leaves the flag set.
- R8: While a drive is empty its disk-change flag stays set, including across seeks that move the head.
- R9: A pulse on a drive's `media_eject` bit sets its flag and marks it empty. A pulse on `media_insert` marks it loaded and leaves the flag unchanged.
- R10: A `dir_rd` strobe loads `dir_data` with the selected drive's flag in bit 7 and zeros in bits 6..0, one cycle later. Reads never clear the flag.
- R11: Drives are independent. A seek or media event on one drive leaves every other drive's cylinder, head and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seek_req | input | 1 | One-cycle seek request |
| seek_drive | input | DRV_W | Drive addressed by the seek |
| seek_mode | input | 2 | 0/3 absolute, 1 inward relative, 2 outward relative |
| seek_value | input | CYL_W | Target cylinder or relative count |
| seek_head | input | 1 | Head recorded with the seek |
| media_insert | input | NUM_DRV | Per-drive media insert pulse |
| media_eject | input | NUM_DRV | Per-drive media eject pulse |
| dir_rd | input | 1 | Status read strobe |
| sel_drive | input | DRV_W | Drive shown on the status outputs |
| sel_pcn | output | CYL_W | Present cylinder of the selected drive |
| sel_head | output | 1 | Head of the selected drive |
| sel_dskchg | output | 1 | Live disk-change flag of the selected drive |
| dir_data | output | 8 | Status byte captured on `dir_rd` (flag in bit 7) |
| seek_done | output | 1 | Completion pulse, one cycle after each request |
| step_evt | output | 1 | Pulse when a seek changed the cylinder |

## Verification
The bench builds the tracker with two drives, an 8-bit cylinder field and MAX_CYL set to 12. The small maximum lets an inward relative seek of 20 hit the upper clamp in a single request. The 8-bit field lets an absolute target of 200 check clamping of out-of-range values. Having two drives lets the bench confirm that the second drive's cylinder and flag stay put while the first is seeked, loaded and ejected.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  // Seek request encoding; value 3 is treated as absolute
  typedef enum logic [1:0] {
    SM_ABS = 2'd0,
    SM_IN  = 2'd1,
    SM_OUT = 2'd2
  } seek_mode_e;

  localparam int DIR_CHG_BIT = 7;
endpackage

// File: rtl/fdt_seek_calc.sv
module fdt_seek_calc #(
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 79
) (
  input  logic [CYL_W-1:0] cur_cyl,
  input  logic [CYL_W-1:0] req_val,
  input  logic [1:0]       req_mode,
  output logic [CYL_W-1:0] next_cyl,
  output logic             moves
);
  import fdt_pkg::*;

  localparam logic [CYL_W:0] MAX_EXT = (CYL_W+1)'(MAX_CYL);

  function automatic logic [CYL_W-1:0] clamp_top(input logic [CYL_W:0] v);
    return (v > MAX_EXT) ? MAX_EXT[CYL_W-1:0] : v[CYL_W-1:0];
  endfunction

  function automatic logic [CYL_W-1:0] step_in(input logic [CYL_W-1:0] c,
                                               input logic [CYL_W-1:0] n);
    return clamp_top({1'b0, c} + {1'b0, n});
  endfunction

  function automatic logic [CYL_W-1:0] step_out(input logic [CYL_W-1:0] c,
                                                input logic [CYL_W-1:0] n);
    return (n >= c) ? '0 : c - n;
  endfunction

  always_comb begin
    case (seek_mode_e'(req_mode))
      SM_IN:   next_cyl = step_in(cur_cyl, req_val);
      SM_OUT:  next_cyl = step_out(cur_cyl, req_val);
      default: next_cyl = clamp_top({1'b0, req_val});
    endcase
    moves = (next_cyl != cur_cyl);
  end
endmodule

// File: rtl/fdt_drive_slot.sv
module fdt_drive_slot #(
  parameter int CYL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [CYL_W-1:0] target,
  input  logic             moves,
  input  logic             head_in,
  input  logic             insert,
  input  logic             eject,
  output logic [CYL_W-1:0] pcn,
  output logic             head,
  output logic             present,
  output logic             dskchg,
  output logic             stepped
);
  // A real step is a hit that changes the cylinder
  logic real_step;
  assign real_step = hit && moves;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcn     <= '0;
      head    <= 1'b0;
      present <= 1'b0;
      dskchg  <= 1'b1;
      stepped <= 1'b0;
    end else begin
      stepped <= real_step;
      if (hit) begin
        pcn  <= target;
        head <= head_in;
      end
      if (eject)       present <= 1'b0;
      else if (insert) present <= 1'b1;
      // Eject dominates; clear uses media state before this edge
      if (eject)                      dskchg <= 1'b1;
      else if (real_step && present)  dskchg <= 1'b0;
    end
  end
endmodule

// File: rtl/fdt_drive_tracker.sv
module fdt_drive_tracker #(
  parameter int NUM_DRV = 4,
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 79,
  localparam int DRV_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seek_req,
  input  logic [DRV_W-1:0]   seek_drive,
  input  logic [1:0]         seek_mode,
  input  logic [CYL_W-1:0]   seek_value,
  input  logic               seek_head,
  input  logic [NUM_DRV-1:0] media_insert,
  input  logic [NUM_DRV-1:0] media_eject,
  input  logic               dir_rd,
  input  logic [DRV_W-1:0]   sel_drive,
  output logic [CYL_W-1:0]   sel_pcn,
  output logic               sel_head,
  output logic               sel_dskchg,
  output logic [7:0]         dir_data,
  output logic               seek_done,
  output logic               step_evt
);
  import fdt_pkg::*;

  // Per-drive state brought out as named wires for the checker
  logic [CYL_W-1:0]   pcn_vec [NUM_DRV];
  logic [NUM_DRV-1:0] head_vec;
  logic [NUM_DRV-1:0] present_vec;
  logic [NUM_DRV-1:0] dskchg_vec;
  logic [NUM_DRV-1:0] stepped_vec;

  logic [CYL_W-1:0] cur_cyl;
  logic [CYL_W-1:0] next_cyl;
  logic             moves;

  assign cur_cyl = pcn_vec[seek_drive];

  fdt_seek_calc #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_calc (
    .cur_cyl  (cur_cyl),
    .req_val  (seek_value),
    .req_mode (seek_mode),
    .next_cyl (next_cyl),
    .moves    (moves)
  );

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
    logic hit;
    assign hit = seek_req && (seek_drive == DRV_W'(i));
    fdt_drive_slot #(.CYL_W(CYL_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .target  (next_cyl),
      .moves   (moves),
      .head_in (seek_head),
      .insert  (media_insert[i]),
      .eject   (media_eject[i]),
      .pcn     (pcn_vec[i]),
      .head    (head_vec[i]),
      .present (present_vec[i]),
      .dskchg  (dskchg_vec[i]),
      .stepped (stepped_vec[i])
    );
  end

  assign sel_pcn    = pcn_vec[sel_drive];
  assign sel_head   = head_vec[sel_drive];
  assign sel_dskchg = dskchg_vec[sel_drive];
  assign step_evt   = |stepped_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seek_done <= 1'b0;
      dir_data  <= '0;
    end else begin
      seek_done <= seek_req;
      if (dir_rd) begin
        dir_data              <= '0;
        dir_data[DIR_CHG_BIT] <= dskchg_vec[sel_drive];
      end
    end
  end
endmodule

// File: rtl/fdt_tracker_chk.sv
module fdt_tracker_chk #(
  parameter int NUM_DRV = 4,
  parameter int CYL_W   = 8,
  parameter int MAX_CYL = 79
) (
  input logic               clk,
  input logic               rst_n,
  input logic               seek_req,
  input logic [NUM_DRV-1:0] media_insert,
  input logic [NUM_DRV-1:0] media_eject,
  input logic               dir_rd,
  input logic               seek_done,
  input logic               step_evt,
  input logic [CYL_W-1:0]   pcn_vec [NUM_DRV],
  input logic [NUM_DRV-1:0] present_vec,
  input logic [NUM_DRV-1:0] dskchg_vec,
  input logic [NUM_DRV-1:0] stepped_vec
);
  assert_done_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seek_req |=> seek_done);
  assert_done_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !seek_req |=> !seek_done);
  assert_step_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> seek_done);
  assert_read_harmless_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rd && !seek_req && media_eject == '0 && media_insert == '0)
      |=> $stable(dskchg_vec));

  for (genvar i = 0; i < NUM_DRV; i++) begin : g_chk
    assert_empty_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !present_vec[i] |-> dskchg_vec[i]);
    assert_clear_needs_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dskchg_vec[i]) |-> (stepped_vec[i] && $past(present_vec[i])));
    assert_eject_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      media_eject[i] |=> (dskchg_vec[i] && !present_vec[i]));
    assert_pcn_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pcn_vec[i] <= CYL_W'(MAX_CYL));
  end
endmodule

bind fdt_drive_tracker fdt_tracker_chk #(
  .NUM_DRV(NUM_DRV), .CYL_W(CYL_W), .MAX_CYL(MAX_CYL)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seek_req     (seek_req),
  .media_insert (media_insert),
  .media_eject  (media_eject),
  .dir_rd       (dir_rd),
  .seek_done    (seek_done),
  .step_evt     (step_evt),
  .pcn_vec      (pcn_vec),
  .present_vec  (present_vec),
  .dskchg_vec   (dskchg_vec),
  .stepped_vec  (stepped_vec)
);

// File: tb/sim_fdt_drive_tracker.sv
module sim_fdt_drive_tracker;
  localparam int NUM_DRV = 2;
  localparam int CYL_W   = 8;
  localparam int MAX_CYL = 12;
  localparam int DRV_W   = 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               seek_req = 1'b0;
  logic [DRV_W-1:0]   seek_drive = '0;
  logic [1:0]         seek_mode = '0;
  logic [CYL_W-1:0]   seek_value = '0;
  logic               seek_head = 1'b0;
  logic [NUM_DRV-1:0] media_insert = '0;
  logic [NUM_DRV-1:0] media_eject = '0;
  logic               dir_rd = 1'b0;
  logic [DRV_W-1:0]   sel_drive = '0;
  logic [CYL_W-1:0]   sel_pcn;
  logic               sel_head;
  logic               sel_dskchg;
  logic [7:0]         dir_data;
  logic               seek_done;
  logic               step_evt;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fdt_drive_tracker #(.NUM_DRV(NUM_DRV), .CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u0 (
    .clk(clk), .rst_n(rst_n), .seek_req(seek_req), .seek_drive(seek_drive),
    .seek_mode(seek_mode), .seek_value(seek_value), .seek_head(seek_head),
    .media_insert(media_insert), .media_eject(media_eject), .dir_rd(dir_rd),
    .sel_drive(sel_drive), .sel_pcn(sel_pcn), .sel_head(sel_head),
    .sel_dskchg(sel_dskchg), .dir_data(dir_data), .seek_done(seek_done),
    .step_evt(step_evt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(input int drv, input int pcn, input int hd, input int chg,
                      input string tag);
    @(negedge clk);
    sel_drive = DRV_W'(drv);
    #1;
    chk({tag, " pcn"}, int'(sel_pcn), pcn);
    chk({tag, " head"}, int'(sel_head), hd);
    chk({tag, " dskchg"}, int'(sel_dskchg), chg);
  endtask

  // mode 0 abs, 1 inward, 2 outward
  task automatic do_seek(input int drv, input int mode, input int val, input int hd,
                         input int exp_step, input string tag);
    @(negedge clk);
    seek_req = 1'b1; seek_drive = DRV_W'(drv); seek_mode = 2'(mode);
    seek_value = CYL_W'(val); seek_head = hd[0];
    @(negedge clk);
    seek_req = 1'b0;
    chk({tag, " R5 seek_done"}, int'(seek_done), 1);
    chk({tag, " R6 step_evt"}, int'(step_evt), exp_step);
    @(negedge clk);
    chk({tag, " R5 done drops"}, int'(seek_done), 0);
  endtask

  task automatic media(input int drv, input bit ins);
    @(negedge clk);
    if (ins) media_insert[drv] = 1'b1; else media_eject[drv] = 1'b1;
    @(negedge clk);
    media_insert = '0; media_eject = '0;
  endtask

  task automatic read_dir(input int drv, input int exp, input string tag);
    @(negedge clk);
    sel_drive = DRV_W'(drv); dir_rd = 1'b1;
    @(negedge clk);
    dir_rd = 1'b0;
    chk({tag, " R10 dir_data"}, int'(dir_data), exp);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 dir_data", int'(dir_data), 0);
    chk("R1 seek_done", int'(seek_done), 0);
    chk("R1 step_evt", int'(step_evt), 0);
    look(0, 0, 0, 1, "R1 drv0");
    look(1, 0, 0, 1, "R1 drv1");
  endtask

  task automatic t_empty();
    read_dir(0, 8'h80, "R10 empty read1");
    read_dir(0, 8'h80, "R10 empty read2");
    do_seek(0, 0, 1, 0, 1, "R8 empty seek");
    look(0, 1, 0, 1, "R8 empty after step");
    read_dir(0, 8'h80, "R10 empty read3");
  endtask

  task automatic t_insert_change();
    media(0, 1'b1);
    look(0, 1, 0, 1, "R9 insert keeps flag");
    do_seek(0, 0, 1, 0, 0, "R7 same cyl");
    look(0, 1, 0, 1, "R7 same cyl flag");
    do_seek(0, 0, 2, 0, 1, "R7 real step");
    look(0, 2, 0, 0, "R7 cleared");
    read_dir(0, 8'h00, "R10 loaded read");
    media(0, 1'b0);
    look(0, 2, 0, 1, "R9 eject sets");
    do_seek(0, 0, 5, 0, 1, "R8 empty again");
    look(0, 5, 0, 1, "R8 still set");
  endtask

  task automatic t_relative();
    media(0, 1'b1);
    do_seek(0, 0, 0, 0, 1, "R2 abs to 0");
    look(0, 0, 0, 0, "R2 at 0");
    do_seek(0, 1, 1, 0, 1, "R3 in 1");
    look(0, 1, 0, 0, "R3 in 1");
    do_seek(0, 2, 1, 0, 1, "R4 out 1");
    look(0, 0, 0, 0, "R4 out 1");
    do_seek(0, 2, 3, 0, 0, "R4 out sat");
    look(0, 0, 0, 0, "R4 sat at 0");
    do_seek(0, 1, 20, 0, 1, "R3 in sat");
    look(0, 12, 0, 0, "R3 sat at max");
    do_seek(0, 2, 5, 0, 1, "R4 out 5");
    look(0, 7, 0, 0, "R4 out 5");
    do_seek(0, 0, 200, 0, 1, "R2 abs clamp");
    look(0, 12, 0, 0, "R2 clamp");
  endtask

  task automatic t_head_indep();
    do_seek(0, 0, 8, 1, 1, "R2 head1");
    look(0, 8, 1, 0, "R2 cyl8 head1");
    look(1, 0, 0, 1, "R11 drv1 untouched");
    media(1, 1'b1);
    do_seek(1, 0, 3, 0, 1, "R11 drv1 seek");
    look(1, 3, 0, 0, "R11 drv1 moved");
    look(0, 8, 1, 0, "R11 drv0 kept");
    read_dir(1, 8'h00, "R10 drv1 read");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_empty();
    t_insert_change();
    t_relative();
    t_head_indep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule